// File: doc/BRIEF.md
# Alarm comparator and interrupt status register

This block sits next to a real-time clock's timekeeping chain. It holds three alarm bytes, one each for seconds, minutes and hours, and a control byte whose upper bits enable three interrupt sources. It also keeps a status byte that records three kinds of event:

- a periodic tick from the rate generator;
- an alarm match;
- the end of a time update.

Neighbouring logic supplies the current seconds, minutes and hours, a one-cycle update-done strobe and a one-cycle periodic tick. When the update-done strobe fires, the block compares the three time fields against the alarm bytes. Any alarm byte with both of its top bits set counts as a wildcard for its field.

A host reaches the block through a byte-wide port addressed by a 4-bit register index. Reading the status byte returns its value and then clears it, so a software handler reads once and sees every pending event. The active-low interrupt output stays low while any latched event has its enable set.

Top module: `rtc_alarm_irq`

## Requirements
- R1: The seconds, minutes and hours alarm bytes are written and read at register indices 1, 3 and 5. The control byte is written and read at index 11. Unused indices read as zero. All registers reset to zero.
- R2: When the update-done strobe is high and each time field equals its alarm byte, the alarm flag (status bit 5) is set from the next cycle.
- R3: An alarm byte whose bits 7 and 6 are both 1 matches every value of its time field.
- R4: If any non-wildcard alarm byte differs from its time field at the strobe, the alarm flag is not set.
- R5: A time match while the update-done strobe is low does not set the alarm flag.
- R6: A periodic tick sets the periodic flag (status bit 6). An update-done strobe sets the update-ended flag (status bit 4). Each flag is set from the next cycle.
- R7: Event flags latch whether or not they are enabled. Status bit 7 is 1 exactly when some flag is set together with its enable: control bit 6 for periodic, bit 5 for alarm, bit 4 for update-ended.
- R8: A read at the status index (12) returns the current status byte. From the next cycle every flag is clear.
- R9: An event that arrives in the same cycle as a status read is kept set after the read.
- R10: The interrupt output is low exactly when status bit 7 is 1. Status bits 3..0 read as 0, and a write to index 12 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_i | input | 8 | Current seconds field |
| min_i | input | 8 | Current minutes field |
| hour_i | input | 8 | Current hours field |
| upd_done_i | input | 1 | One-cycle strobe at the end of a time update |
| periodic_tick_i | input | 1 | One-cycle periodic event |
| reg_idx_i | input | 4 | Register index |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; at index 12 it clears the status flags |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected index, combinational |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The alarm comparator is tried in four situations:

- an exact match on all three fields;
- a match held while the strobe stays low, which separates strobe gating from plain comparison;
- a single mismatching field, once in each position;
- wildcard bytes at 0xC0 and 0xFF set against field values that differ from them.

Flag handling is tried with events that arrive while their enable is off, which separates latching from gating. It is also tried with reads that coincide with a tick or a strobe, which separates clear-priority from set-priority. Every cycle, a behavioural model predicts the read data and the interrupt level, and both are compared with the design.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned N_FIELDS = 3;   // sec, min, hour
  localparam int unsigned N_EVT    = 3;

  localparam logic [IDX_W-1:0] IDX_CTRL = 4'd11;
  localparam logic [IDX_W-1:0] IDX_STAT = 4'd12;

  // status / control bit positions
  localparam int unsigned BIT_SUM = 7;
  localparam int unsigned BIT_PER = 6;
  localparam int unsigned BIT_ALM = 5;
  localparam int unsigned BIT_UPD = 4;

  // event vector order: {per, alm, upd}
  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } evt_t;

  function automatic logic [IDX_W-1:0] alarm_idx(input int unsigned f);
    return IDX_W'(2 * f + 1);
  endfunction
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int unsigned NF = rtc_irq_pkg::N_FIELDS,
  parameter int unsigned DW = rtc_irq_pkg::DATA_W
) (
  input  logic [NF-1:0][DW-1:0] cur_i,
  input  logic [NF-1:0][DW-1:0] alarm_i,
  output logic                  match_o
);
  logic [NF-1:0] hit;

  for (genvar g = 0; g < NF; g++) begin : g_field
    logic wild;
    assign wild   = &alarm_i[g][DW-1 -: 2];
    assign hit[g] = wild || (alarm_i[g] == cur_i[g]);
  end

  assign match_o = &hit;
endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_irq_pkg::*;
#(
  parameter int unsigned NF = N_FIELDS,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IW-1:0]         idx_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [NF-1:0][DW-1:0] alarm_o,
  output logic [DW-1:0]         ctrl_o
);
  for (genvar g = 0; g < NF; g++) begin : g_alarm
    localparam logic [IW-1:0] MY_IDX = IW'(2 * g + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          alarm_o[g] <= '0;
      else if (wr_en_i && idx_i == MY_IDX)  alarm_o[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ctrl_o <= '0;
    else if (wr_en_i && idx_i == IDX_CTRL)  ctrl_o <= wdata_i;
  end
endmodule

// File: rtl/rtc_evt_flags.sv
module rtc_evt_flags
  import rtc_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  evt_t evt_i,
  input  logic clr_i,
  output evt_t flag_o
);
  // clear and set in one cycle: the new event survives the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= '0;
    else if (clr_i)  flag_o <= evt_i;
    else             flag_o <= flag_o | evt_i;
  end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] sec_i,
  input  logic [DW-1:0] min_i,
  input  logic [DW-1:0] hour_i,
  input  logic          upd_done_i,
  input  logic          periodic_tick_i,
  input  logic [IW-1:0] reg_idx_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_no
);
  localparam int unsigned NF = N_FIELDS;

  logic [NF-1:0][DW-1:0] cur;
  logic [NF-1:0][DW-1:0] alarm_q;
  logic [DW-1:0]         ctrl_q;
  logic                  match;
  evt_t                  evt;
  evt_t                  flag_q;
  evt_t                  en;
  logic                  sum;
  logic                  stat_rd;

  assign cur = {hour_i, min_i, sec_i};

  rtc_alarm_regs #(.NF(NF), .DW(DW), .IW(IW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .idx_i   (reg_idx_i),
    .wdata_i (wdata_i),
    .alarm_o (alarm_q),
    .ctrl_o  (ctrl_q)
  );

  rtc_alarm_match #(.NF(NF), .DW(DW)) u_match (
    .cur_i   (cur),
    .alarm_i (alarm_q),
    .match_o (match)
  );

  assign evt.per = periodic_tick_i;
  assign evt.alm = upd_done_i && match;
  assign evt.upd = upd_done_i;
  assign stat_rd = rd_en_i && (reg_idx_i == IDX_STAT);

  rtc_evt_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .clr_i  (stat_rd),
    .flag_o (flag_q)
  );

  assign en     = {ctrl_q[BIT_PER], ctrl_q[BIT_ALM], ctrl_q[BIT_UPD]};
  assign sum    = |(flag_q & en);
  assign irq_no = ~sum;

  always_comb begin
    rdata_o = '0;
    for (int f = 0; f < int'(NF); f++)
      if (reg_idx_i == alarm_idx(f)) rdata_o = alarm_q[f];
    if (reg_idx_i == IDX_CTRL) rdata_o = ctrl_q;
    if (reg_idx_i == IDX_STAT) begin
      rdata_o[BIT_SUM] = sum;
      rdata_o[BIT_PER] = flag_q.per;
      rdata_o[BIT_ALM] = flag_q.alm;
      rdata_o[BIT_UPD] = flag_q.upd;
    end
  end
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk
  import rtc_irq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       upd_done_i,
  input logic       periodic_tick_i,
  input logic       rd_en_i,
  input logic       wr_en_i,
  input logic [3:0] reg_idx_i,
  input logic [7:0] rdata_o,
  input logic       irq_no,
  input evt_t       flag_q
);
  logic rd_stat;
  assign rd_stat = rd_en_i && reg_idx_i == IDX_STAT;

  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && !upd_done_i && !periodic_tick_i) |=> (flag_q == '0));

  a_r9_event_kept_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && periodic_tick_i) |=> flag_q.per);

  a_r6_tick_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periodic_tick_i |=> flag_q.per);

  a_r6_upd_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_i |=> flag_q.upd);

  a_r5_alarm_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q.alm) |-> $past(upd_done_i));

  a_r7_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_stat && !upd_done_i && !periodic_tick_i) |=> $stable(flag_q));

  a_r10_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_idx_i == IDX_STAT) |-> (rdata_o[3:0] == 4'h0));

  a_r10_irq_vs_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_idx_i == IDX_STAT) |-> (irq_no == !rdata_o[BIT_SUM]));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .upd_done_i      (upd_done_i),
  .periodic_tick_i (periodic_tick_i),
  .rd_en_i         (rd_en_i),
  .wr_en_i         (wr_en_i),
  .reg_idx_i       (reg_idx_i),
  .rdata_o         (rdata_o),
  .irq_no          (irq_no),
  .flag_q          (flag_q)
);

// File: tb/rtc_alarm_irq_tb.sv
module rtc_alarm_irq_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sec = 0, mins = 0, hour = 0, wdata = 0;
  logic       upd = 0, tick = 0, wr = 0, rd = 0;
  logic [3:0] idx = 0;
  logic [7:0] rdata;
  logic       irq_n;

  int vectors = 0;
  int errors  = 0;

  // reference model state
  int m_alarm[3];
  int m_ctrl;
  bit m_per, m_alm, m_upd;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sec_i(sec), .min_i(mins), .hour_i(hour),
    .upd_done_i(upd), .periodic_tick_i(tick), .reg_idx_i(idx),
    .wr_en_i(wr), .rd_en_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_no(irq_n)
  );

  function automatic bit m_sum();
    return (m_per && m_ctrl[6]) || (m_alm && m_ctrl[5]) || (m_upd && m_ctrl[4]);
  endfunction

  function automatic int m_read(input int i);
    case (i)
      1:  return m_alarm[0];
      3:  return m_alarm[1];
      5:  return m_alarm[2];
      11: return m_ctrl;
      12: return (int'(m_sum()) << 7) | (int'(m_per) << 6) | (int'(m_alm) << 5) | (int'(m_upd) << 4);
      default: return 0;
    endcase
  endfunction

  function automatic bit fld_hit(input int a, input int v);
    return ((a & 'hC0) == 'hC0) || (a == v);
  endfunction

  task automatic check(input string tag);
    int exp_rd;
    bit exp_irq;
    exp_rd  = m_read(int'(idx));
    exp_irq = !m_sum();
    vectors++;
    if (int'(rdata) != exp_rd || irq_n != exp_irq) begin
      errors++;
      $display("FAIL %s idx=%0d rdata=%02h irq_n=%0b expected rdata=%02h irq_n=%0b",
               tag, idx, rdata, irq_n, exp_rd[7:0], exp_irq);
    end
  endtask

  // drive one cycle at negedge, compare, advance model at posedge
  task automatic step(input string tag, input int i, input bit w, input bit r,
                      input int wd, input bit u, input bit t);
    bit hit, ev_per, ev_alm, ev_upd;
    idx = 4'(i); wr = w; rd = r; wdata = 8'(wd); upd = u; tick = t;
    #1;
    check(tag);
    @(posedge clk);
    hit = fld_hit(m_alarm[0], int'(sec)) && fld_hit(m_alarm[1], int'(mins)) &&
          fld_hit(m_alarm[2], int'(hour));
    ev_per = t; ev_upd = u; ev_alm = u && hit;
    if (r && i == 12) begin
      m_per = ev_per; m_alm = ev_alm; m_upd = ev_upd;
    end else begin
      m_per |= ev_per; m_alm |= ev_alm; m_upd |= ev_upd;
    end
    if (w) begin
      if (i == 1) m_alarm[0] = wd;
      if (i == 3) m_alarm[1] = wd;
      if (i == 5) m_alarm[2] = wd;
      if (i == 11) m_ctrl = wd;
    end
    @(negedge clk);
  endtask

  task automatic peek(input string tag, input int i);
    step(tag, i, 0, 0, 0, 0, 0);
  endtask

  task automatic set_time(input int s, input int m, input int h);
    sec = 8'(s); mins = 8'(m); hour = 8'(h);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    m_alarm = '{0, 0, 0}; m_ctrl = 0; m_per = 0; m_alm = 0; m_upd = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++) begin idx = 4'(i); #1; check("R1 reset"); end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 register access
    step("R1 wr sec alarm", 1, 1, 0, 'h30, 0, 0);
    step("R1 wr min alarm", 3, 1, 0, 'h15, 0, 0);
    step("R1 wr hour alarm", 5, 1, 0, 'h08, 0, 0);
    step("R1 wr ctrl", 11, 1, 0, 'h20, 0, 0);
    for (int i = 0; i < 16; i++) peek("R1 readback", i);

    // R5 match without strobe
    set_time('h30, 'h15, 'h08);
    peek("R5 no strobe", 12);
    peek("R5 no strobe", 12);
    // R2 exact match with strobe
    step("R2 strobe", 12, 0, 0, 0, 1, 0);
    peek("R2 alarm set R7 R10 irq", 12);
    // R8 read clears
    step("R8 read", 12, 0, 1, 0, 0, 0);
    peek("R8 cleared", 12);

    // R4 mismatch in each field
    set_time('h31, 'h15, 'h08); step("R4 sec diff", 12, 0, 0, 0, 1, 0); peek("R4", 12);
    step("R8 read", 12, 0, 1, 0, 0, 0);
    set_time('h30, 'h16, 'h08); step("R4 min diff", 12, 0, 0, 0, 1, 0); peek("R4", 12);
    step("R8 read", 12, 0, 1, 0, 0, 0);
    set_time('h30, 'h15, 'h09); step("R4 hour diff", 12, 0, 0, 0, 1, 0); peek("R4", 12);
    step("R8 read", 12, 0, 1, 0, 0, 0);

    // R3 wildcards
    step("R3 wild sec", 1, 1, 0, 'hC0, 0, 0);
    set_time('h59, 'h15, 'h08); step("R3 strobe", 12, 0, 0, 0, 1, 0); peek("R3 hit", 12);
    step("R8 read", 12, 0, 1, 0, 0, 0);
    step("R3 wild hour", 5, 1, 0, 'hFF, 0, 0);
    set_time('h00, 'h15, 'h23); step("R3 strobe", 12, 0, 0, 0, 1, 0); peek("R3 hit", 12);
    step("R8 read", 12, 0, 1, 0, 0, 0);
    step("R3 partial top", 3, 1, 0, 'h80, 0, 0);
    step("R3 not wild", 12, 0, 0, 0, 1, 0); peek("R3 0x80 no hit", 12);
    step("R8 read", 12, 0, 1, 0, 0, 0);

    // R6 R7 tick latches with enable off
    step("R7 ctrl off", 11, 1, 0, 'h00, 0, 0);
    step("R6 tick", 12, 0, 0, 0, 0, 1);
    peek("R7 latched irq high", 12);
    step("R7 enable per", 11, 1, 0, 'h40, 0, 0);
    peek("R7 irq low", 12);
    // R9 event during read
    step("R9 read+tick", 12, 0, 1, 0, 0, 1);
    peek("R9 kept", 12);
    step("R9 read+upd", 12, 0, 1, 0, 1, 0);
    peek("R9 upd kept", 12);
    step("R7 enable upd", 11, 1, 0, 'h10, 0, 0);
    peek("R7 upd irq", 12);
    // R10 write to status ignored
    step("R10 wr stat", 12, 1, 0, 'hFF, 0, 0);
    peek("R10 unchanged", 12);
    step("R8 read", 12, 0, 1, 0, 0, 0);
    peek("R10 irq released", 12);
    peek("R10 ctrl view", 11);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule